// File: doc/BRIEF.md
# Two-Master DRAM Port Arbiter

This block decides who drives a single DRAM controller port. There are two bus masters: a CPU-side system bus and a display controller. There is also a maintenance path for refresh and page-management work. Maintenance forms the top priority level. The two masters share the lower level. Between them, a read wins over a write at the same decision point, and a rotating pointer settles the remaining ties. After reset the pointer favours the CPU side.

Each master presents a request, a read flag, a burst flag and a done strobe. The done strobe pulses on the last cycle of each transaction (one beat). Maintenance sources raise one-cycle ticks. The arbiter latches those ticks until the controller acknowledges the maintenance slot. A decision is taken only when the port is idle or the current owner closes its transaction, and the chosen grant appears on the following clock edge. A master that ends a beat with its burst flag still high keeps the port. A single-beat master that was still requesting when a burst took the port over is parked, and it is served first once the burst ends.

Top module: `dram_port_arb`

## Requirements
- R1: While reset is high and on the first edge after it, `grant` is 00 and `mnt_grant` is 0. With both masters requesting the same direction at the first decision, the CPU side (bit 0) wins.
- R2: A tick on any `mnt_tick` bit is held pending until `mnt_ack` is seen while `mnt_grant` is high. A tick in that same cycle keeps it pending. At the next decision point a pending maintenance request wins over both masters. `mnt_grant` then stays high until `mnt_ack`.
- R3: Grants change only when the port is idle, when the owning master pulses its own `m_done` bit, or when `mnt_ack` arrives during maintenance. A done strobe from a master that does not own the port has no effect.
- R4: When both masters request at a decision point and exactly one has its `m_rd` bit high (1 = read), that master is granted.
- R5: When both masters request the same direction, the rotating pointer decides the winner. Each master grant moves the pointer to the other master, so singles alternate 0, 1, 0.
- R6: A master that is the only requester is granted again right after its own transaction.
- R7: A done strobe from the owner, with its `m_burst` and `m_req` bits still high, keeps the grant for the next beat. This holds even when maintenance is pending.
- R8: A master that was doing singles and still requesting when the other master's burst took the port is parked. When the burst ends it is granted ahead of the read-over-write rule, after any pending maintenance.
- R9: At most one of `grant[0]`, `grant[1]` and `mnt_grant` is high in any cycle.
- R10: With no request and nothing pending at a decision point, all grants go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 2 | Request per master; bit 0 CPU side, bit 1 display |
| m_rd | input | 2 | 1 = read, 0 = write, per master |
| m_burst | input | 2 | Burst expected; high on a done beat keeps the grant |
| m_done | input | 2 | Transaction-done strobe per master |
| mnt_tick | input | MNT_SRC | Maintenance tick per source (refresh, page management) |
| mnt_ack | input | 1 | Controller has finished the maintenance slot |
| grant | output | 2 | Registered one-hot master grant |
| mnt_grant | output | 1 | Registered maintenance grant |

## Verification
The hardest state to reach is a parked master. Getting there needs a boundary where a single-beat master is still requesting while the other master wins with its burst flag set. A refresh tick must then land in the middle of the burst, and the parked master's read flag must favour the other side. Only that combination shows that the burst holds against pending maintenance, that maintenance comes next, and that parking outranks the read-over-write rule. The vector table builds this up one cycle at a time from a known pointer value.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int NUM_MST = 2;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DSP  = 2'd2,
    OWN_MNT  = 2'd3
  } owner_t;
endpackage

// File: rtl/dpa_mnt_latch.sv
module dpa_mnt_latch #(
  parameter int SRC = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SRC-1:0] tick,
  input  logic           ack_ok,
  output logic           pend_q,
  output logic           pend_now
);
  logic any_tick;

  assign any_tick = |tick;
  // a fresh tick beats a clearing acknowledge
  assign pend_now = any_tick | (pend_q & ~ack_ok);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= pend_now;
  end

  p_ack_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (ack_ok && !any_tick) |=> !pend_q);
  p_tick_set_r2: assert property (@(posedge clk) disable iff (rst)
    any_tick |=> pend_q);
endmodule

// File: rtl/dpa_master_pick.sv
module dpa_master_pick #(
  parameter int NM = 2
) (
  input  logic [NM-1:0] req,
  input  logic [NM-1:0] rd,
  input  logic [NM-1:0] park,
  input  logic          ptr,
  output logic          any,
  output logic          win
);
  logic [NM-1:0] parked_live;

  assign parked_live = park & req;
  assign any = |req;

  always_comb begin
    if (|parked_live)            win = parked_live[1];
    else if (&req) begin
      if (rd[0] != rd[1])        win = rd[1];
      else                       win = ptr;
    end
    else                         win = req[1];
  end
endmodule

// File: rtl/dram_port_arb.sv
module dram_port_arb
  import dpa_pkg::*;
#(
  parameter int MNT_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MST-1:0] m_req,
  input  logic [NUM_MST-1:0] m_rd,
  input  logic [NUM_MST-1:0] m_burst,
  input  logic [NUM_MST-1:0] m_done,
  input  logic [MNT_SRC-1:0] mnt_tick,
  input  logic               mnt_ack,
  output logic [NUM_MST-1:0] grant,
  output logic               mnt_grant
);
  owner_t             owner_q, owner_d;
  logic               ptr_q, ptr_d;
  logic [NUM_MST-1:0] park_q, park_d;
  logic               cur_idx, done_own, ack_ok, boundary, burst_keep;
  logic               pend_q, pend_now, pick_any, pick_win;

  assign cur_idx  = (owner_q == OWN_DSP);
  assign done_own = ((owner_q == OWN_CPU) & m_done[0]) |
                    ((owner_q == OWN_DSP) & m_done[1]);
  assign ack_ok   = (owner_q == OWN_MNT) & mnt_ack;
  assign boundary = (owner_q == OWN_NONE) | done_own | ack_ok;
  assign burst_keep = done_own & m_burst[cur_idx] & m_req[cur_idx];

  dpa_mnt_latch #(.SRC(MNT_SRC)) u_mnt (
    .clk(clk), .rst(rst), .tick(mnt_tick), .ack_ok(ack_ok),
    .pend_q(pend_q), .pend_now(pend_now)
  );

  dpa_master_pick #(.NM(NUM_MST)) u_pick (
    .req(m_req), .rd(m_rd), .park(park_q), .ptr(ptr_q),
    .any(pick_any), .win(pick_win)
  );

  always_comb begin
    owner_d = owner_q;
    ptr_d   = ptr_q;
    park_d  = park_q & m_req;
    if (boundary && !burst_keep) begin
      if (pend_now) begin
        owner_d = OWN_MNT;
      end else if (pick_any) begin
        owner_d = pick_win ? OWN_DSP : OWN_CPU;
        ptr_d   = ~pick_win;
        park_d[pick_win] = 1'b0;
        if (m_burst[pick_win] && done_own && (cur_idx != pick_win) && m_req[cur_idx])
          park_d[cur_idx] = 1'b1;
      end else begin
        owner_d = OWN_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q   <= OWN_NONE;
      ptr_q     <= 1'b0;
      park_q    <= '0;
      grant     <= '0;
      mnt_grant <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      ptr_q     <= ptr_d;
      park_q    <= park_d;
      grant     <= {owner_d == OWN_DSP, owner_d == OWN_CPU};
      mnt_grant <= (owner_d == OWN_MNT);
    end
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant, mnt_grant}));
  p_cpu_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && !m_done[0]) |=> grant[0]);
  p_dsp_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && !m_done[1]) |=> grant[1]);
  p_mnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (mnt_grant && !mnt_ack) |=> mnt_grant);
  p_idle_mnt_r2: assert property (@(posedge clk) disable iff (rst)
    (grant == 2'b00 && !mnt_grant && pend_q) |=> mnt_grant);
  p_burst_cpu_r7: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && m_done[0] && m_burst[0] && m_req[0]) |=> grant[0]);
  p_burst_dsp_r7: assert property (@(posedge clk) disable iff (rst)
    (grant[1] && m_done[1] && m_burst[1] && m_req[1]) |=> grant[1]);
  p_rotate_r5: assert property (@(posedge clk) disable iff (rst)
    (grant[0] && m_done[0] && !m_burst[0] && m_req == 2'b11 &&
     m_rd[0] == m_rd[1] && !pend_now && park_q == 2'b00) |=> grant[1]);
endmodule

// File: tb/dram_port_arb_tb.sv
`timescale 1ns/100ps
module dram_port_arb_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] m_req, m_rd, m_burst, m_done, mnt_tick;
  logic       mnt_ack;
  logic [1:0] grant;
  logic       mnt_grant;
  int         checks = 0;
  int         errors = 0;
  bit         done_flag = 1'b0;

  always #2.5 clk = ~clk;

  dram_port_arb u_dut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_rd(m_rd), .m_burst(m_burst),
    .m_done(m_done), .mnt_tick(mnt_tick), .mnt_ack(mnt_ack),
    .grant(grant), .mnt_grant(mnt_grant)
  );

  // fields: req rd burst done rtick ptick ack | exp_grant exp_mnt
  localparam int NV = 22;
  localparam logic [13:0] VEC [NV] = '{
    14'b11_11_00_00_0_0_0_01_0, // 0  R1 CPU first
    14'b11_11_00_10_0_0_0_01_0, // 1  R3 foreign done ignored
    14'b11_11_00_01_0_0_0_10_0, // 2  R5 rotate
    14'b11_11_00_10_0_0_0_01_0, // 3  R5 rotate back
    14'b01_11_00_01_0_0_0_01_0, // 4  R6 sole requester
    14'b11_01_00_01_0_0_0_01_0, // 5  R4 CPU read beats pointer
    14'b11_10_00_01_0_0_0_10_0, // 6  R4 display read
    14'b11_11_00_00_1_0_0_10_0, // 7  R3 tick mid-transaction
    14'b11_11_00_10_0_0_0_00_1, // 8  R2 maintenance wins
    14'b11_11_00_11_0_0_0_00_1, // 9  R3 done ignored during maint
    14'b11_11_00_00_0_0_1_01_0, // 10 R2 ack releases
    14'b11_11_10_01_0_0_0_10_0, // 11 R8 burst takes port, CPU parked
    14'b11_11_10_10_1_0_0_10_0, // 12 R7 burst holds over tick
    14'b11_11_00_10_0_0_0_00_1, // 13 R2 maint after burst
    14'b11_10_00_00_0_0_1_01_0, // 14 R8 parked beats read
    14'b00_00_00_01_0_0_0_00_0, // 15 R10 idle
    14'b00_00_00_00_0_0_0_00_0, // 16 R10 stays idle
    14'b10_00_00_00_0_0_0_10_0, // 17 R6 display from idle
    14'b10_00_00_10_0_1_0_00_1, // 18 R2 page tick
    14'b00_00_00_00_1_0_1_00_1, // 19 R2 tick with ack
    14'b00_00_00_00_0_0_1_00_0, // 20 R10 release to idle
    14'b00_00_00_00_0_0_0_00_0  // 21 R10 idle
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1";  1: return "R3";  2: return "R5";  3: return "R5";
      4: return "R6";  5: return "R4";  6: return "R4";  7: return "R3";
      8: return "R2";  9: return "R3";  10: return "R2"; 11: return "R8";
      12: return "R7"; 13: return "R2"; 14: return "R8"; 17: return "R6";
      18: return "R2"; 19: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {grant,mnt_grant} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive_idle();
    m_req = '0; m_rd = '0; m_burst = '0; m_done = '0; mnt_tick = '0; mnt_ack = 1'b0;
  endtask

  initial begin
    drive_idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R1", {grant, mnt_grant}, 3'b000);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 chk("R1", {grant, mnt_grant}, 3'b000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {m_req, m_rd, m_burst, m_done} = VEC[i][13:6];
      mnt_tick = {VEC[i][4], VEC[i][5]};
      mnt_ack  = VEC[i][3];
      @(posedge clk); #1;
      chk(vtag(i), {grant, mnt_grant}, VEC[i][2:0]);
      checks++;
      if ($countones({grant, mnt_grant}) > 1) begin
        errors++;
        $display("FAIL R9: {grant,mnt_grant} actual %b expected at most one high", {grant, mnt_grant});
      end
    end

    // R1: reset in the middle of a burst clears grants and restores pointer
    @(negedge clk); drive_idle(); m_req = 2'b10; m_burst = 2'b10;
    @(posedge clk); #1 chk("R6", {grant, mnt_grant}, 3'b100);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 chk("R1", {grant, mnt_grant}, 3'b000);
    @(negedge clk); rst = 1'b0; m_req = 2'b11; m_rd = 2'b00; m_burst = 2'b00;
    @(posedge clk); #1 chk("R1", {grant, mnt_grant}, 3'b010);
    // R7: CPU burst of three beats with display waiting
    @(negedge clk); m_burst = 2'b01; m_done = 2'b01;
    @(posedge clk); #1 chk("R7", {grant, mnt_grant}, 3'b010);
    @(negedge clk); m_done = 2'b01;
    @(posedge clk); #1 chk("R7", {grant, mnt_grant}, 3'b010);
    @(negedge clk); m_burst = 2'b00; m_done = 2'b01;
    @(posedge clk); #1 chk("R5", {grant, mnt_grant}, 3'b100);
    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule